// File: doc/BRIEF.md
# Random-Search CNF Satisfier

This block looks for a satisfying assignment of a conjunctive-normal-form formula that is fixed in the logic. The formula is (x1 OR x3 OR NOT x4) AND (x4) AND (x2 OR NOT x3), over four variables. A linear feedback shift register makes a fresh pseudo-random word on every enabled clock. A candidate register holds the word under test, and a combinational clause network scores that register.

While the formula result is false, the candidate register keeps taking new words. When the result turns true, a sticky flag is set, the generator stops, and the winning word leaves the block one bit per cycle on a serial pin. The parallel word and a cycle count of the search are also visible.

A user raises the enable, waits for the found flag, then reads four serial bits. The count of enabled search cycles stays on its output until the next reset. The target clock is 50 MHz.

Top module: `sat_rand_search`

## Requirements
- R1: A synchronous active-high reset clears the candidate word, the found flag and the cycle count, and puts the generator at its nonzero seed (default 8'h01).
- R2: While the enable is low, no state changes: the word, the flag, the count and the generator all hold.
- R3: The generator is a Fibonacci LFSR of LFSR_W bits with a maximal-length tap set. Each step moves every bit one place toward the MSB and enters the XOR of the tap bits at bit 0. For the default width of 8, the taps are bits 7, 5, 4 and 3. Its low four bits form a candidate, and bit i-1 is variable x_i.
- R4: The formula result F is the AND of the three clauses (x1|x3|~x4), (x4) and (x2|~x3), evaluated on the candidate word with bit i-1 as x_i.
- R5: On each enabled edge where F is 0 and the flag is clear, the word loads the current generator state (low four bits).
- R6: On an enabled edge where F is 1 and the flag is clear, the flag sets and the word holds. The flag never rises with a word that fails the formula.
- R7: The flag is sticky until reset, and the generator stops advancing once the flag is set.
- R8: While the flag is set, each enabled edge moves the word one place toward the MSB and fills bit 0 with 0. The serial pin always shows the word's MSB. In the four enabled cycles after the flag rises it therefore shows x4, x3, x2 and x1, and 0 after that.
- R9: The count rises by one on each enabled edge while the flag is clear, stops at all ones, and holds once the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enable for search and shift-out |
| ser_out | output | 1 | Serial satisfying assignment, MSB first |
| sol_word | output | 4 | Candidate / capture register contents |
| found | output | 1 | Sticky flag: a satisfying word was seen |
| search_cycles | output | CNT_W | Enabled search cycles until the flag set |

## Verification
The bench goes after the detection edge. A design that kept loading on that edge would replace the winner with a new word, and the serial bits would then fail the formula. It pauses the enable both mid-search and during shift-out, because a design that let the generator or the counter run while disabled would report a different count and stream. It resets after a completed search and repeats the search, to catch a flag or counter that survives reset. It also checks the zeros after the fourth serial bit, which show whether a design re-arms loading once the shifted word no longer satisfies the formula.

// File: rtl/sat_search_pkg.sv
package sat_search_pkg;

  localparam int NVARS       = 4;
  localparam int NCLAUSES    = 3;
  localparam int LFSR_MAX_W  = 168;

  typedef logic [NVARS-1:0] cand_t;

  // Positive literal mask of clause c (bit i-1 = x_i).
  function automatic cand_t clause_pos(input int c);
    case (c)
      0:       return 4'b0101;  // x1, x3
      1:       return 4'b1000;  // x4
      2:       return 4'b0010;  // x2
      default: return 4'b0000;
    endcase
  endfunction

  // Negated literal mask of clause c.
  function automatic cand_t clause_neg(input int c);
    case (c)
      0:       return 4'b1000;  // ~x4
      2:       return 4'b0100;  // ~x3
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic formula_holds(input cand_t v);
    logic ok;
    ok = 1'b1;
    for (int c = 0; c < NCLAUSES; c++) begin
      ok = ok & ((|(v & clause_pos(c))) | (|(~v & clause_neg(c))));
    end
    return ok;
  endfunction

  function automatic logic [LFSR_MAX_W-1:0] tap_set(input int a, input int b,
                                                    input int c, input int d);
    logic [LFSR_MAX_W-1:0] m;
    m = '0;
    if (a > 0) m[a-1] = 1'b1;
    if (b > 0) m[b-1] = 1'b1;
    if (c > 0) m[c-1] = 1'b1;
    if (d > 0) m[d-1] = 1'b1;
    return m;
  endfunction

  // Maximal-length tap positions (1-based) for widths 3..24.
  function automatic logic [LFSR_MAX_W-1:0] lfsr_taps(input int w);
    case (w)
      3:  return tap_set(3, 2, 0, 0);
      4:  return tap_set(4, 3, 0, 0);
      5:  return tap_set(5, 3, 0, 0);
      6:  return tap_set(6, 5, 0, 0);
      7:  return tap_set(7, 6, 0, 0);
      8:  return tap_set(8, 6, 5, 4);
      9:  return tap_set(9, 5, 0, 0);
      10: return tap_set(10, 7, 0, 0);
      11: return tap_set(11, 9, 0, 0);
      12: return tap_set(12, 6, 4, 1);
      13: return tap_set(13, 4, 3, 1);
      14: return tap_set(14, 5, 3, 1);
      15: return tap_set(15, 14, 0, 0);
      16: return tap_set(16, 15, 13, 4);
      17: return tap_set(17, 14, 0, 0);
      18: return tap_set(18, 11, 0, 0);
      19: return tap_set(19, 6, 2, 1);
      20: return tap_set(20, 17, 0, 0);
      21: return tap_set(21, 19, 0, 0);
      22: return tap_set(22, 21, 0, 0);
      23: return tap_set(23, 18, 0, 0);
      24: return tap_set(24, 23, 22, 17);
      default: return tap_set(w, w - 1, 0, 0);
    endcase
  endfunction

endpackage

// File: rtl/sat_lfsr.sv
module sat_lfsr
  import sat_search_pkg::*;
#(
  parameter int              W    = 8,
  parameter logic [W-1:0]    SEED = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] state
);

  localparam logic [W-1:0] TAPS = W'(lfsr_taps(W));

  logic [W-1:0] q;
  logic         fb;

  assign fb    = ^(q & TAPS);
  assign state = q;

  always_ff @(posedge clk) begin
    if (rst)      q <= SEED;
    else if (adv) q <= {q[W-2:0], fb};
  end

endmodule

// File: rtl/sat_clause_eval.sv
module sat_clause_eval
  import sat_search_pkg::*;
(
  input  cand_t                cand,
  output logic [NCLAUSES-1:0]  clause_ok,
  output logic                 f_sat
);

  for (genvar c = 0; c < NCLAUSES; c++) begin : g_clause
    localparam cand_t POS = clause_pos(c);
    localparam cand_t NEG = clause_neg(c);
    assign clause_ok[c] = (|(cand & POS)) | (|(~cand & NEG));
  end

  assign f_sat = &clause_ok;

endmodule

// File: rtl/sat_capture_shift.sv
module sat_capture_shift #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic         shift_en,
  input  logic [N-1:0] din,
  output logic [N-1:0] word,
  output logic         msb
);

  logic [N-1:0] q;

  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (load_en)  q <= din;
    else if (shift_en) q <= {q[N-2:0], 1'b0};
  end

  assign word = q;
  assign msb  = q[N-1];

endmodule

// File: rtl/sat_search_ctrl.sv
module sat_search_ctrl #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             f_sat,
  output logic             found,
  output logic             load_en,
  output logic             shift_en,
  output logic             adv_en,
  output logic [CNT_W-1:0] cnt
);

  logic             found_q;
  logic             detect;
  logic [CNT_W-1:0] cnt_q;

  assign detect   = en & ~found_q & f_sat;
  assign load_en  = en & ~found_q & ~f_sat;
  assign shift_en = en & found_q;
  assign adv_en   = en & ~found_q;

  always_ff @(posedge clk) begin
    if (rst)         found_q <= 1'b0;
    else if (detect) found_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                            cnt_q <= '0;
    else if (adv_en && (cnt_q != '1))   cnt_q <= cnt_q + CNT_W'(1);
  end

  assign found = found_q;
  assign cnt   = cnt_q;

endmodule

// File: rtl/sat_rand_search.sv
module sat_rand_search
  import sat_search_pkg::*;
#(
  parameter int                 LFSR_W = 8,
  parameter logic [LFSR_W-1:0]  SEED   = 1,
  parameter int                 CNT_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic             ser_out,
  output logic [3:0]       sol_word,
  output logic             found,
  output logic [CNT_W-1:0] search_cycles
);

  logic [LFSR_W-1:0]   lfsr_q;
  cand_t               cand_q;
  logic [NCLAUSES-1:0] clause_ok;
  logic                f_sat;
  logic                load_en;
  logic                shift_en;
  logic                adv_en;

  sat_lfsr #(.W(LFSR_W), .SEED(SEED)) gen_i (
    .clk   (clk),
    .rst   (rst),
    .adv   (adv_en),
    .state (lfsr_q)
  );

  sat_capture_shift #(.N(NVARS)) cap_i (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .shift_en (shift_en),
    .din      (lfsr_q[NVARS-1:0]),
    .word     (cand_q),
    .msb      (ser_out)
  );

  sat_clause_eval eval_i (
    .cand      (cand_q),
    .clause_ok (clause_ok),
    .f_sat     (f_sat)
  );

  sat_search_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .f_sat    (f_sat),
    .found    (found),
    .load_en  (load_en),
    .shift_en (shift_en),
    .adv_en   (adv_en),
    .cnt      (search_cycles)
  );

  assign sol_word = cand_q;

endmodule

// File: rtl/sat_rand_search_chk.sv
module sat_rand_search_chk
  import sat_search_pkg::*;
#(
  parameter int LFSR_W = 8,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              found,
  input logic [3:0]        word,
  input logic [CNT_W-1:0]  cnt,
  input logic [LFSR_W-1:0] lfsr,
  input logic              f_sat
);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (word == '0 && cnt == '0 && !found));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(word) && $stable(cnt) && $stable(found) && $stable(lfsr)));

  a_r3_gen_nonzero: assert property (@(posedge clk) disable iff (rst)
    lfsr != '0);

  a_r5_load_candidate: assert property (@(posedge clk) disable iff (rst)
    (en && !found && !f_sat) |=> (word == $past(lfsr[3:0])));

  a_r6_detect_holds: assert property (@(posedge clk) disable iff (rst)
    (en && !found && f_sat) |=> (found && $stable(word)));

  a_r6_rise_satisfies: assert property (@(posedge clk) disable iff (rst)
    $rose(found) |-> formula_holds(word));

  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    found |=> found);

  a_r7_gen_stops: assert property (@(posedge clk) disable iff (rst)
    found |=> $stable(lfsr));

  a_r8_shift_up: assert property (@(posedge clk) disable iff (rst)
    (en && found) |=> (word == {$past(word[2:0]), 1'b0}));

  a_r9_cnt_hold: assert property (@(posedge clk) disable iff (rst)
    found |=> $stable(cnt));

  a_r9_cnt_step: assert property (@(posedge clk) disable iff (rst)
    (en && !found && cnt != '1) |=> (cnt == $past(cnt) + CNT_W'(1)));

endmodule

bind sat_rand_search sat_rand_search_chk #(.LFSR_W(LFSR_W), .CNT_W(CNT_W)) chk_i (
  .clk   (clk),
  .rst   (rst),
  .en    (en),
  .found (found),
  .word  (sol_word),
  .cnt   (search_cycles),
  .lfsr  (lfsr_q),
  .f_sat (f_sat)
);

// File: tb/sat_rand_search_tb_top.sv
module sat_rand_search_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic        ser_out;
  logic [3:0]  sol_word;
  logic        found;
  logic [31:0] search_cycles;

  always #4 clk = ~clk;

  sat_rand_search dut_i (
    .clk           (clk),
    .rst           (rst),
    .en            (en),
    .ser_out       (ser_out),
    .sol_word      (sol_word),
    .found         (found),
    .search_cycles (search_cycles)
  );

  typedef struct {
    logic [3:0]  word;
    logic        fnd;
    logic [31:0] cnt;
    logic        ser;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   ended    = 0;

  // Bench view of the formula: all three clauses must hold.
  function automatic logic b_sat(input logic [3:0] a);
    logic c1, c2, c3;
    c1 = a[0] | a[2] | ~a[3];
    c2 = a[3];
    c3 = a[1] | ~a[2];
    return c1 & c2 & c3;
  endfunction

  // Eight-bit generator step with taps at bits 7,5,4,3 (R3).
  function automatic logic [7:0] b_next(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  logic [7:0]  m_gen;
  logic [3:0]  m_word;
  logic        m_found;
  logic [31:0] m_cnt;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic push_exp(input string tag);
    exp_t e;
    e.word = m_word; e.fnd = m_found; e.cnt = m_cnt; e.ser = m_word[3]; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1;
    @(posedge clk); #1;
    m_gen = 8'h01; m_word = '0; m_found = 1'b0; m_cnt = '0;
    push_exp(tag);
    rst = 1'b0;
  endtask

  // Driver: one clock with the given enable, expected state queued.
  task automatic tick(input logic e, input string tag);
    en = e;
    @(posedge clk); #1;
    if (e) begin
      if (!m_found) begin
        if (b_sat(m_word)) m_found = 1'b1;
        else               m_word  = m_gen[3:0];
        m_gen = b_next(m_gen);
        m_cnt = m_cnt + 1;
      end else begin
        m_word = {m_word[2:0], 1'b0};
      end
    end
    push_exp(tag);
  endtask

  // Monitor: compares each queued item half a cycle later.
  logic       prev_found = 1'b0;
  int         ser_n = 0;
  logic [3:0] ser_bits = '0;

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(sol_word == e.word, e.tag, "word", 32'(sol_word), 32'(e.word));
      check(found == e.fnd, e.tag, "found", 32'(found), 32'(e.fnd));
      check(search_cycles == e.cnt, e.tag, "count", search_cycles, e.cnt);
      check(ser_out == e.ser, e.tag, "serial", 32'(ser_out), 32'(e.ser));
      if (found && !prev_found)
        check(b_sat(sol_word) == 1'b1, "R6", "word at flag rise satisfies",
              32'(b_sat(sol_word)), 32'd1);
      if (found && ser_n < 4) begin
        ser_bits[3 - ser_n] = ser_out;
        ser_n++;
      end
      prev_found = found;
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  logic [7:0]  s;
  int          j_first;
  logic [3:0]  exp_sol;

  task automatic search_and_drain(input string pass);
    int guard;
    guard = 0;
    while (!m_found && guard < 600) begin
      tick(1'b1, {pass, " R5 search"});
      guard++;
    end
    @(negedge clk); #1;
    check(search_cycles == 32'(j_first + 2), "R9", {pass, " final count"},
          search_cycles, 32'(j_first + 2));
    check(sol_word == exp_sol, "R6", {pass, " captured word"},
          32'(sol_word), 32'(exp_sol));
  endtask

  initial begin
    // Independent search: first generator state whose low nibble satisfies.
    s = 8'h01; j_first = 0;
    while (!b_sat(s[3:0]) && j_first < 300) begin
      s = b_next(s);
      j_first++;
    end
    exp_sol = s[3:0];

    do_reset("R1 reset");
    do_reset("R1 reset");
    for (int i = 0; i < 3; i++) tick(1'b0, "R2 idle before start");
    for (int i = 0; i < 4; i++) tick(1'b1, "R3 R5 early search");
    for (int i = 0; i < 3; i++) tick(1'b0, "R2 paused search");

    search_and_drain("pass1");
    ser_n = 0;
    tick(1'b1, "R8 shift");
    tick(1'b0, "R2 paused shift");
    for (int i = 0; i < 5; i++) tick(1'b1, "R8 R7 shift and tail");
    @(negedge clk); #1;
    check(ser_bits == exp_sol, "R8", "serial bits reassembled",
          32'(ser_bits), 32'(exp_sol));
    check(b_sat(ser_bits) == 1'b1, "R4", "serial word satisfies formula",
          32'(b_sat(ser_bits)), 32'd1);
    check(found == 1'b1 && ser_out == 1'b0, "R7", "sticky flag with zero tail",
          32'({found, ser_out}), 32'b10);

    do_reset("R1 reset after search");
    @(negedge clk); #1;
    check(found == 1'b0 && search_cycles == 0, "R1", "cleared after search",
          32'({found, search_cycles[0]}), 32'd0);
    prev_found = 1'b0;
    search_and_drain("pass2");
    for (int i = 0; i < 2; i++) tick(1'b1, "R9 hold after found");

    @(negedge clk); #1;
    while (q.size() > 0) @(negedge clk);
    #1;
    finish_run();
  end

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule